// File: doc/BRIEF.md
# Inline Data Upload Packer

This block sits behind a command front end that delivers a burst of 32-bit arguments carrying inline payload. Software first arms an upload by pulsing an arm strobe together with a destination base address, a byte budget, a rectangle (width, height, start column, start row) and a mode flag. Each argument that arrives while the upload is armed is split into up to four bytes, least significant byte first, which are appended to an internal staging buffer. Bytes that would land past the byte budget are discarded, even when that happens partway through a word.

Nothing reaches memory until an argument flagged as the last of its burst is accepted. The block then drains the staging buffer through a byte-wide write request port with a valid/ready handshake. In linear mode the bytes go to consecutive addresses from the base. In tiled mode the block walks the rectangle row by row, column by column, presents each (column, row) pair to an external offset lookup and writes each byte to the base plus the returned offset. The walk ends early once the budget runs out. While draining, the block reports busy and back-pressures further arguments. After the drain the upload is disarmed.

The staging depth is a parameter. An arm request whose byte budget exceeds that depth is clamped to the depth and raises an error flag.

Top module: `inline_upload_packer`

## Requirements
- R1: After reset, busy, wr_valid and size_err are low and arg_ready is high.
- R2: Byte k of each accepted argument (bits 8k+7 down to 8k, k = 0..3) is stored at the next free staging position in ascending k, so staging byte i comes from argument i/4, lane i mod 4, counted from the start of the armed upload.
- R3: Once the staging write position equals the byte budget, the remaining lanes of the current argument and all further arguments store nothing.
- R4: Arguments accepted while no upload is armed cause no write and do not raise busy.
- R5: No write is requested before the last-flagged argument is accepted; busy is high from the cycle after that acceptance, and arg_ready is low whenever busy is high.
- R6: In linear mode (cfg_tiled = 0) the drain issues exactly budget writes, write i carrying address base + i and staging byte i; positions never filled since arming carry 0.
- R7: In tiled mode (cfg_tiled = 1) writes follow rows start_y .. height-1 (outer) and columns start_x .. width-1 (inner), stop once budget bytes have been written, present the current column on tile_x and row on tile_y, and use address base + tile_off with the next staging byte.
- R8: While wr_valid is high and wr_ready is low, wr_valid stays high and wr_data, tile_x and tile_y hold their values.
- R9: busy falls in the cycle after the final write is accepted (or after one cycle when the drain has no writes), and the upload is then disarmed.
- R10: A budget above DEPTH is clamped to DEPTH and sets size_err; size_err is recomputed at every accepted arm.
- R11: An arm pulse while filling restarts the upload with the new settings and a cleared buffer; an arm pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_arm | input | 1 | Arm strobe, captures the cfg_* values |
| cfg_base | input | AW | Destination base address |
| cfg_size | input | CSW | Byte budget |
| cfg_width | input | CW | Rectangle width (exclusive column bound) |
| cfg_height | input | CW | Rectangle height (exclusive row bound) |
| cfg_start_x | input | CW | First column of the walk |
| cfg_start_y | input | CW | First row of the walk |
| cfg_tiled | input | 1 | 1 = tiled scatter, 0 = linear |
| arg_valid | input | 1 | Argument present |
| arg_data | input | 32 | Argument word |
| arg_last | input | 1 | Argument closes the burst |
| arg_ready | output | 1 | Argument can be accepted |
| busy | output | 1 | Drain in progress |
| size_err | output | 1 | Budget was clamped at the last arm |
| tile_x | output | CW | Column presented to the offset lookup |
| tile_y | output | CW | Row presented to the offset lookup |
| tile_off | input | AW | Byte offset returned for (tile_x, tile_y), same cycle |
| wr_valid | output | 1 | Byte write request |
| wr_addr | output | AW | Byte write address |
| wr_data | output | 8 | Byte write data |
| wr_ready | input | 1 | Write accepted when high with wr_valid |

## Verification
The assertions assume that tile_off is a pure function of tile_x and tile_y within a cycle, and that the memory side may stall for any number of cycles but eventually raises wr_ready. The stimulus computes tile_off combinationally from the presented coordinates, toggles wr_ready from a seeded random stream that is never stuck low for long, and only changes arguments and arm strobes away from the clock edge. Random bursts vary mode, budget, rectangle and word count, including early last arguments and budgets beyond the staging depth, while directed cases cover mid-word budget stops, empty walks and arm pulses during fill and drain.

// File: rtl/iup_pkg.sv
package iup_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_DRAIN = 2'd2
    } iup_state_e;

    localparam int LANES = 4;

endpackage

// File: rtl/iup_lane_unpack.sv
module iup_lane_unpack #(
    parameter int SW = 7
) (
    input  logic [SW-1:0] wr_pos,
    input  logic [SW-1:0] budget,
    output logic [3:0]    lane_en,
    output logic [2:0]    adv
);
    localparam int PW = SW + 1;

    always_comb begin
        adv = '0;
        for (int k = 0; k < iup_pkg::LANES; k++) begin
            lane_en[k] = ({1'b0, wr_pos} + PW'(k)) < {1'b0, budget};
            adv        = adv + {2'b00, lane_en[k]};
        end
    end
endmodule

// File: rtl/iup_stage_buf.sv
module iup_stage_buf #(
    parameter int DEPTH = 64,
    parameter int SW    = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [3:0]    lane_wr,
    input  logic [SW-1:0] wr_base,
    input  logic [31:0]   wr_word,
    input  logic [SW-1:0] rd_idx,
    output logic [7:0]    rd_byte
);
    localparam int PW = SW + 1;
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [7:0]    mem_q [DEPTH];
    logic [7:0]    mem_d [DEPTH];
    logic [PW-1:0] pos;

    always_comb begin
        mem_d = mem_q;
        pos   = '0;
        if (clr) begin
            for (int i = 0; i < DEPTH; i++) mem_d[i] = 8'h00;
        end else begin
            for (int k = 0; k < iup_pkg::LANES; k++) begin
                pos = {1'b0, wr_base} + PW'(k);
                if (lane_wr[k] && (pos < PW'(DEPTH)))
                    mem_d[pos[IW-1:0]] = wr_word[8*k +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '{default: 8'h00};
        else        mem_q <= mem_d;
    end

    assign rd_byte = (rd_idx < SW'(DEPTH)) ? mem_q[rd_idx[IW-1:0]] : 8'h00;
endmodule

// File: rtl/iup_walker.sv
module iup_walker #(
    parameter int CW = 8
) (
    input  logic [CW-1:0] cur_x,
    input  logic [CW-1:0] cur_y,
    input  logic [CW-1:0] lim_x,
    input  logic [CW-1:0] lim_y,
    input  logic [CW-1:0] first_x,
    output logic          in_rect,
    output logic [CW-1:0] nxt_x,
    output logic [CW-1:0] nxt_y,
    output logic          nxt_in_rect
);
    logic [CW:0] x_inc;
    logic        row_end;

    always_comb begin
        in_rect     = (cur_x < lim_x) && (cur_y < lim_y);
        x_inc       = {1'b0, cur_x} + 1'b1;
        row_end     = x_inc >= {1'b0, lim_x};
        nxt_x       = row_end ? first_x : x_inc[CW-1:0];
        nxt_y       = row_end ? cur_y + 1'b1 : cur_y;
        nxt_in_rect = (nxt_x < lim_x) && (nxt_y < lim_y) && !(row_end && (cur_y == {CW{1'b1}}));
    end
endmodule

// File: rtl/inline_upload_packer.sv
module inline_upload_packer #(
    parameter int DEPTH = 64,
    parameter int AW    = 32,
    parameter int CW    = 8,
    parameter int CSW   = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_arm,
    input  logic [AW-1:0] cfg_base,
    input  logic [CSW-1:0] cfg_size,
    input  logic [CW-1:0] cfg_width,
    input  logic [CW-1:0] cfg_height,
    input  logic [CW-1:0] cfg_start_x,
    input  logic [CW-1:0] cfg_start_y,
    input  logic          cfg_tiled,
    input  logic          arg_valid,
    input  logic [31:0]   arg_data,
    input  logic          arg_last,
    output logic          arg_ready,
    output logic          busy,
    output logic          size_err,
    output logic [CW-1:0] tile_x,
    output logic [CW-1:0] tile_y,
    input  logic [AW-1:0] tile_off,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    input  logic          wr_ready
);
    import iup_pkg::*;

    localparam int SW = $clog2(DEPTH + 1);

    typedef struct packed {
        iup_state_e    st;
        logic [SW-1:0] wp;
        logic [SW-1:0] rp;
        logic [SW-1:0] size;
        logic [AW-1:0] base;
        logic [CW-1:0] wid;
        logic [CW-1:0] hgt;
        logic [CW-1:0] sx;
        logic [CW-1:0] sy;
        logic [CW-1:0] x;
        logic [CW-1:0] y;
        logic          tiled;
        logic          err;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic [3:0]    lane_en, lane_wr;
    logic [2:0]    adv;
    logic          buf_clr;
    logic [7:0]    rd_byte;
    logic          in_rect, nxt_in_rect;
    logic [CW-1:0] x_nx, y_nx;
    logic          drain_more;
    logic          over;

    iup_lane_unpack #(.SW(SW)) u_lanes (
        .wr_pos  (ctl_q.wp),
        .budget  (ctl_q.size),
        .lane_en (lane_en),
        .adv     (adv)
    );

    iup_stage_buf #(.DEPTH(DEPTH), .SW(SW)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (buf_clr),
        .lane_wr (lane_wr),
        .wr_base (ctl_q.wp),
        .wr_word (arg_data),
        .rd_idx  (ctl_q.rp),
        .rd_byte (rd_byte)
    );

    iup_walker #(.CW(CW)) u_walk (
        .cur_x       (ctl_q.x),
        .cur_y       (ctl_q.y),
        .lim_x       (ctl_q.wid),
        .lim_y       (ctl_q.hgt),
        .first_x     (ctl_q.sx),
        .in_rect     (in_rect),
        .nxt_x       (x_nx),
        .nxt_y       (y_nx),
        .nxt_in_rect (nxt_in_rect)
    );

    always_comb begin
        ctl_d      = ctl_q;
        buf_clr    = 1'b0;
        lane_wr    = '0;
        over       = cfg_size > CSW'(DEPTH);
        drain_more = (ctl_q.rp < ctl_q.size) && (!ctl_q.tiled || in_rect);
        case (ctl_q.st)
            ST_IDLE, ST_FILL: begin
                if (cfg_arm) begin
                    ctl_d.st    = ST_FILL;
                    ctl_d.wp    = '0;
                    ctl_d.rp    = '0;
                    ctl_d.size  = over ? SW'(DEPTH) : SW'(cfg_size);
                    ctl_d.err   = over;
                    ctl_d.base  = cfg_base;
                    ctl_d.wid   = cfg_width;
                    ctl_d.hgt   = cfg_height;
                    ctl_d.sx    = cfg_start_x;
                    ctl_d.sy    = cfg_start_y;
                    ctl_d.tiled = cfg_tiled;
                    buf_clr     = 1'b1;
                end else if ((ctl_q.st == ST_FILL) && arg_valid) begin
                    lane_wr  = lane_en;
                    ctl_d.wp = ctl_q.wp + SW'(adv);
                    if (arg_last) begin
                        ctl_d.st = ST_DRAIN;
                        ctl_d.rp = '0;
                        ctl_d.x  = ctl_q.sx;
                        ctl_d.y  = ctl_q.sy;
                    end
                end
            end
            ST_DRAIN: begin
                if (!drain_more) begin
                    ctl_d.st = ST_IDLE;
                end else if (wr_ready) begin
                    ctl_d.rp = ctl_q.rp + 1'b1;
                    if (ctl_q.tiled) begin
                        ctl_d.x = x_nx;
                        ctl_d.y = y_nx;
                    end
                    if (((ctl_q.rp + 1'b1) >= ctl_q.size) || (ctl_q.tiled && !nxt_in_rect))
                        ctl_d.st = ST_IDLE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign arg_ready = (ctl_q.st != ST_DRAIN);
    assign busy      = (ctl_q.st == ST_DRAIN);
    assign size_err  = ctl_q.err;
    assign tile_x    = ctl_q.x;
    assign tile_y    = ctl_q.y;
    assign wr_valid  = busy && drain_more;
    assign wr_data   = rd_byte;
    assign wr_addr   = ctl_q.tiled ? (ctl_q.base + tile_off) : (ctl_q.base + AW'(ctl_q.rp));

    AST_BUSY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(arg_valid && arg_last)); // R5
    AST_NO_ARG_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !arg_ready); // R5
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_data) && $stable(tile_x) && $stable(tile_y)); // R8
    AST_PTR_IN_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.wp <= ctl_q.size); // R3
    AST_SIZE_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.size <= SW'(DEPTH)); // R10
    AST_UNARMED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_IDLE) && !cfg_arm |=> !busy); // R4
    AST_TILE_IN_RECT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && ctl_q.tiled |-> (tile_x < ctl_q.wid) && (tile_y < ctl_q.hgt)); // R7
endmodule

// File: tb/inline_upload_packer_tb.sv
`timescale 1ns/1ps
module inline_upload_packer_tb;
    localparam int DEPTH = 64;
    localparam int AW    = 32;
    localparam int CW    = 8;
    localparam int CSW   = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_arm = 1'b0;
    logic [AW-1:0]  cfg_base = '0;
    logic [CSW-1:0] cfg_size = '0;
    logic [CW-1:0]  cfg_width = '0, cfg_height = '0, cfg_start_x = '0, cfg_start_y = '0;
    logic           cfg_tiled = 1'b0;
    logic           arg_valid = 1'b0;
    logic [31:0]    arg_data = '0;
    logic           arg_last = 1'b0;
    logic           arg_ready, busy, size_err, wr_valid;
    logic [CW-1:0]  tile_x, tile_y;
    logic [AW-1:0]  tile_off, wr_addr;
    logic [7:0]     wr_data;
    logic           wr_ready = 1'b1;
    bit             stall_en = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    function automatic logic [AW-1:0] toff(input logic [CW-1:0] x, input logic [CW-1:0] y);
        return AW'(y) * 32'd97 + AW'(x) * 32'd5;
    endfunction

    assign tile_off = toff(tile_x, tile_y);

    inline_upload_packer #(.DEPTH(DEPTH), .AW(AW), .CW(CW), .CSW(CSW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_arm(cfg_arm), .cfg_base(cfg_base), .cfg_size(cfg_size),
        .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_start_x(cfg_start_x),
        .cfg_start_y(cfg_start_y), .cfg_tiled(cfg_tiled), .arg_valid(arg_valid),
        .arg_data(arg_data), .arg_last(arg_last), .arg_ready(arg_ready), .busy(busy),
        .size_err(size_err), .tile_x(tile_x), .tile_y(tile_y), .tile_off(tile_off),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready)
    );

    // Bench model state
    logic [7:0]    mbuf [DEPTH];
    int            m_size, m_wp;
    bit            m_armed;
    logic [AW-1:0] m_base;
    int            m_w, m_h, m_sx, m_sy;
    bit            m_tiled;

    // Write log
    logic [AW-1:0] log_a [512];
    logic [7:0]    log_d [512];
    int            log_n = 0;

    always @(posedge clk) begin
        if (rst_n && wr_valid && wr_ready) begin
            if (log_n < 512) begin
                log_a[log_n] = wr_addr;
                log_d[log_n] = wr_data;
            end
            log_n = log_n + 1;
        end
    end

    always @(posedge clk) begin
        #1;
        wr_ready <= stall_en ? (($urandom % 4) != 0) : 1'b1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // R8 monitor: held request under stall
    bit            stall_prev = 1'b0;
    logic [7:0]    pd;
    logic [CW-1:0] px, py;
    always @(negedge clk) begin
        if (rst_n) begin
            if (stall_prev) begin
                chk(wr_valid && wr_data == pd && tile_x == px && tile_y == py, "R8",
                    "held write under stall", {wr_valid, wr_data}, {1'b1, pd});
            end
            stall_prev = wr_valid && !wr_ready;
            pd = wr_data; px = tile_x; py = tile_y;
        end else begin
            stall_prev = 1'b0;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done_flag) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic do_arm(input logic [AW-1:0] base, input int size, input int w, input int h,
                          input int sx, input int sy, input bit tiled);
        cfg_base = base; cfg_size = CSW'(size); cfg_width = CW'(w); cfg_height = CW'(h);
        cfg_start_x = CW'(sx); cfg_start_y = CW'(sy); cfg_tiled = tiled; cfg_arm = 1'b1;
        if (!busy) begin
            for (int i = 0; i < DEPTH; i++) mbuf[i] = 8'h00;
            m_size = (size > DEPTH) ? DEPTH : size;
            m_wp = 0; m_armed = 1'b1; m_base = base;
            m_w = w; m_h = h; m_sx = sx; m_sy = sy; m_tiled = tiled;
        end
        @(negedge clk);
        cfg_arm = 1'b0;
    endtask

    task automatic push(input logic [31:0] word, input bit last);
        bit was_armed;
        was_armed = m_armed;
        arg_valid = 1'b1; arg_data = word; arg_last = last;
        if (m_armed) begin
            for (int k = 0; k < 4; k++) begin
                if (m_wp < m_size) begin
                    mbuf[m_wp] = word[8*k +: 8];
                    m_wp++;
                end
            end
            if (last) m_armed = 1'b0;
        end
        @(negedge clk);
        arg_valid = 1'b0; arg_last = 1'b0;
        if (last && was_armed) begin
            chk(busy == 1'b1, "R5", "busy after last", busy, 1);
            chk(arg_ready == 1'b0, "R5", "arg_ready low while busy", arg_ready, 0);
            chk(log_n == 0, "R5", "no write before drain", log_n, 0);
        end
    endtask

    task automatic wait_idle();
        int g = 0;
        while (busy && g < 5000) begin
            @(negedge clk);
            g++;
        end
        chk(!busy, "R9", "busy drops after drain", busy, 0);
    endtask

    task automatic verify(input string req);
        int en = 0;
        int rd = 0;
        logic [AW-1:0] ea [512];
        logic [7:0]    ed [512];
        if (m_tiled) begin
            for (int y = m_sy; y < m_h && rd < m_size; y++)
                for (int x = m_sx; x < m_w && rd < m_size; x++) begin
                    ea[en] = m_base + toff(CW'(x), CW'(y));
                    ed[en] = mbuf[rd];
                    rd++; en++;
                end
        end else begin
            for (int i = 0; i < m_size; i++) begin
                ea[en] = m_base + AW'(i);
                ed[en] = mbuf[i];
                en++;
            end
        end
        chk(log_n == en, req, "write count", log_n, en);
        if (log_n == en) begin
            for (int i = 0; i < en; i++) begin
                chk(log_a[i] == ea[i], req, $sformatf("addr of write %0d", i), log_a[i], ea[i]);
                chk(log_d[i] == ed[i], req, $sformatf("data of write %0d", i), log_d[i], ed[i]);
            end
        end
        log_n = 0;
    endtask

    task automatic burst(input int nwords);
        for (int i = 0; i < nwords; i++) push($urandom, i == nwords - 1);
        wait_idle();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        m_armed = 1'b0;
        for (int i = 0; i < DEPTH; i++) mbuf[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1", "busy at reset", busy, 0);
        chk(wr_valid == 1'b0, "R1", "wr_valid at reset", wr_valid, 0);
        chk(size_err == 1'b0, "R1", "size_err at reset", size_err, 0);
        chk(arg_ready == 1'b1, "R1", "arg_ready at reset", arg_ready, 1);

        // R4 unarmed arguments ignored
        push(32'hDEADBEEF, 1'b0);
        push(32'h01020304, 1'b1);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R4", "busy stays low unarmed", busy, 0);
        chk(log_n == 0, "R4", "no writes unarmed", log_n, 0);

        // R2 R3 R6: linear, budget stops mid-word, extra words dropped
        do_arm(32'h1000, 6, 0, 0, 0, 0, 1'b0);
        push(32'h44332211, 1'b0);
        push(32'h88776655, 1'b0);
        push(32'hCCBBAA99, 1'b0);
        push(32'h00FFEEDD, 1'b1);
        wait_idle();
        verify("R2/R3 lane order and budget");

        // R6: early last, unfilled positions read zero after re-arm clears
        do_arm(32'h2000, 10, 0, 0, 0, 0, 1'b0);
        push(32'hA1B2C3D4, 1'b1);
        wait_idle();
        verify("R6 linear with zero fill");

        // R7 tiled walk bounded by rectangle
        do_arm(32'h4000, 20, 5, 4, 2, 1, 1'b1);
        burst(5);
        verify("R7 tiled rectangle");

        // R7 tiled walk bounded by budget
        do_arm(32'h5000, 7, 6, 5, 1, 0, 1'b1);
        burst(2);
        verify("R7 tiled budget stop");

        // R7 R9 empty walk: start column past width
        do_arm(32'h6000, 8, 3, 3, 3, 0, 1'b1);
        burst(2);
        verify("R7 empty walk");

        // R9 disarmed after drain
        push(32'h55AA55AA, 1'b1);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && log_n == 0, "R9", "argument after drain ignored", log_n, 0);

        // R10 clamp
        do_arm(32'h7000, 100, 0, 0, 0, 0, 1'b0);
        chk(size_err == 1'b1, "R10", "size_err on oversize", size_err, 1);
        burst(18);
        verify("R10 clamped drain");
        do_arm(32'h7100, 8, 0, 0, 0, 0, 1'b0);
        chk(size_err == 1'b0, "R10", "size_err cleared", size_err, 0);
        burst(2);
        verify("R10 normal after clamp");

        // R11 re-arm during fill restarts
        do_arm(32'h8000, 8, 0, 0, 0, 0, 1'b0);
        push(32'h11111111, 1'b0);
        do_arm(32'h8800, 6, 0, 0, 0, 0, 1'b0);
        push(32'h76543210, 1'b1);
        wait_idle();
        verify("R11 re-arm in fill");

        // R11 arm during drain ignored
        stall_en = 1'b1;
        do_arm(32'h9000, 16, 0, 0, 0, 0, 1'b0);
        for (int i = 0; i < 4; i++) push($urandom, i == 3);
        do_arm(32'hA000, 4, 0, 0, 0, 0, 1'b0);
        wait_idle();
        verify("R11 drain unaffected by arm");
        push(32'h12345678, 1'b1);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && log_n == 0, "R11", "arm during drain not taken", log_n, 0);

        // Random mix, stalled memory side
        for (int it = 0; it < 40; it++) begin
            bit tl = ($urandom % 2) == 1;
            int sz = 1 + ($urandom % 70);
            int w  = 1 + ($urandom % 10);
            int h  = 1 + ($urandom % 8);
            int sx = $urandom % (w + 1);
            int sy = $urandom % (h + 1);
            int nw = ($urandom % 4 == 0) ? 1 + ($urandom % 4) : ((sz + 3) / 4) + ($urandom % 3);
            do_arm($urandom & 32'hFFFF_F000, sz, w, h, sx, sy, tl);
            chk(size_err == (sz > DEPTH), "R10", "size_err random", size_err, sz > DEPTH);
            burst(nw);
            verify(tl ? "R7 random tiled" : "R6 random linear");
        end
        stall_en = 1'b0;

        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule